// File: doc/BRIEF.md
# Translation Lookaside Buffer with Block-Span Entries

This block is a small, fully associative cache of page-to-frame translations. A lookup presents a virtual page number. One cycle later the block returns a valid strobe, a hit flag, a fault flag and the physical frame number. A miss tells the surrounding logic that a page-table walk must resolve the address before the access can go ahead. An entry whose mapping is marked absent raises a fault instead of returning a frame.

Each entry carries a two-bit span code, so one entry can cover a naturally aligned block of 1, 2, 4 or 8 consecutive pages that map to consecutive frames. This lets a few entries cover large mapped regions.

The walker loads new entries through a fill port. Fills go into the slot named by a round-robin pointer, which then advances. A single-cycle flush input empties the whole buffer.

Top module: `gh_tlb`

## Requirements
- R1: `rs_valid` is high in the cycle after a cycle with `lk_req` high, and low after a cycle without it.
- R2: An entry with span code 0 covers one page. A lookup hits only on its exact page number, and `rs_pfn` equals the stored frame.
- R3: Span code h (0, 1, 2, 3 for 1, 2, 4, 8 pages) makes the match ignore the low h bits of the page number. `rs_pfn` is the frame base OR-ed with those low h lookup bits.
- R4: A fill clears the low h bits of both the page and frame numbers it stores, so the bases are aligned to the block size.
- R5: A matching entry with `fl_present` stored as 0 gives `rs_hit`=1, `rs_fault`=1 and `rs_pfn`=0.
- R6: A lookup that matches no valid entry gives `rs_hit`=0, `rs_fault`=0 and `rs_pfn`=0.
- R7: Fills write slots 0, 1, …, ENTRIES-1 in turn and then wrap. The fill after ENTRIES fills replaces the oldest entry.
- R8: `flush` invalidates every entry in one cycle and returns the fill pointer to slot 0. A lookup in the same cycle reports a miss, and a fill in the same cycle is dropped.
- R9: When several valid entries match, the one in the lowest-numbered slot supplies the result.
- R10: A lookup in the same cycle as a fill sees the contents from before that fill. The new entry is visible to lookups from the next cycle on.
- R11: After reset no entry is valid, the fill pointer is at slot 0 and `rs_valid`, `rs_hit`, `rs_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | A valid entry matched |
| rs_fault | output | 1 | Matching entry is marked absent |
| rs_pfn | output | PFN_W | Translated frame number (0 on miss or fault) |
| fl_en | input | 1 | Fill strobe |
| fl_vpn | input | VPN_W | Fill page number |
| fl_pfn | input | PFN_W | Fill frame number |
| fl_hint | input | 2 | Fill span code: 0..3 for 1, 2, 4, 8 pages |
| fl_present | input | 1 | Fill mapping present (0 means absent) |
| flush | input | 1 | Invalidate all entries |

## Verification
Every lookup result comes out of one register stage, so the bench compares `rs_valid`, `rs_hit`, `rs_fault` and `rs_pfn` at the falling edge that follows the rising edge which captured the request. The bench drives all inputs at falling edges and computes the expected result from its own model. That model still holds the contents from before the edge, so the same-cycle fill and flush rules fall out of the order of its updates. The model applies fills and flushes only after the edge, which keeps eviction order and pointer resets aligned with the design.

// File: rtl/gh_tlb_pkg.sv
package gh_tlb_pkg;
   localparam int HINT_W  = 2;
   localparam int LOW_MAX = (1 << HINT_W) - 1;

   typedef logic [HINT_W-1:0] hint_t;

   function automatic logic [LOW_MAX-1:0] low_mask(input hint_t h);
      logic [LOW_MAX-1:0] m;
      m = '0;
      for (int b = 0; b < LOW_MAX; b++) begin
         if (b < int'(h)) m[b] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/gh_tlb_store.sv
module gh_tlb_store
   import gh_tlb_pkg::*;
#(
   parameter int VPN_W   = 16,
   parameter int PFN_W   = 12,
   parameter int ENTRIES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          fl_en,
   input  logic [VPN_W-1:0]              fl_vpn,
   input  logic [PFN_W-1:0]              fl_pfn,
   input  hint_t                         fl_hint,
   input  logic                          fl_present,
   output logic [ENTRIES-1:0]            ent_valid,
   output logic [ENTRIES-1:0]            ent_present,
   output logic [ENTRIES-1:0][HINT_W-1:0] ent_hint,
   output logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
   output logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

   logic [PTR_W-1:0] ptr_q;
   logic [VPN_W-1:0] vpn_al;
   logic [PFN_W-1:0] pfn_al;
   logic             do_fill;

   assign do_fill = fl_en && !flush;
   assign vpn_al  = fl_vpn & ~VPN_W'(low_mask(fl_hint));
   assign pfn_al  = fl_pfn & ~PFN_W'(low_mask(fl_hint));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (flush) begin
         ptr_q <= '0;
      end else if (fl_en) begin
         ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic wr;
      assign wr = do_fill && (ptr_q == PTR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[i]   <= 1'b0;
            ent_present[i] <= 1'b0;
            ent_hint[i]    <= '0;
            ent_vpn[i]     <= '0;
            ent_pfn[i]     <= '0;
         end else if (flush) begin
            ent_valid[i]   <= 1'b0;
         end else if (wr) begin
            ent_valid[i]   <= 1'b1;
            ent_present[i] <= fl_present;
            ent_hint[i]    <= fl_hint;
            ent_vpn[i]     <= vpn_al;
            ent_pfn[i]     <= pfn_al;
         end
      end
   end

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ent_valid == '0 && ptr_q == '0));
   // R7
   ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && !flush) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));
   // R4
   aligned_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && !flush) |=> ((ent_vpn[$past(ptr_q)] & VPN_W'(low_mask(ent_hint[$past(ptr_q)]))) == '0));
endmodule

// File: rtl/gh_tlb_match.sv
module gh_tlb_match
   import gh_tlb_pkg::*;
#(
   parameter int VPN_W   = 16,
   parameter int ENTRIES = 8
) (
   input  logic [VPN_W-1:0]               vpn,
   input  logic [ENTRIES-1:0]             ent_valid,
   input  logic [ENTRIES-1:0][HINT_W-1:0] ent_hint,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
   output logic [ENTRIES-1:0]             hits
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      logic [VPN_W-1:0] care;
      assign care    = ~VPN_W'(low_mask(ent_hint[i]));
      assign hits[i] = ent_valid[i] && (((vpn ^ ent_vpn[i]) & care) == '0);
   end
endmodule

// File: rtl/gh_tlb_prio.sv
module gh_tlb_prio #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   assign grant = req & (~req + 1'b1);
   assign any   = |req;

   // R9
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ($onehot(grant) && ((grant & req) != '0)));
endmodule

// File: rtl/gh_tlb.sv
module gh_tlb
   import gh_tlb_pkg::*;
#(
   parameter int VPN_W   = 16,
   parameter int PFN_W   = 12,
   parameter int ENTRIES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_req,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             rs_valid,
   output logic             rs_hit,
   output logic             rs_fault,
   output logic [PFN_W-1:0] rs_pfn,
   input  logic             fl_en,
   input  logic [VPN_W-1:0] fl_vpn,
   input  logic [PFN_W-1:0] fl_pfn,
   input  logic [1:0]       fl_hint,
   input  logic             fl_present,
   input  logic             flush
);
   if (VPN_W <= LOW_MAX) begin : g_bad_vpn
      $error("gh_tlb: VPN_W must exceed the largest span shift");
   end
   if (PFN_W <= LOW_MAX) begin : g_bad_pfn
      $error("gh_tlb: PFN_W must exceed the largest span shift");
   end
   if (ENTRIES < 2) begin : g_bad_ent
      $error("gh_tlb: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0]             ent_valid;
   logic [ENTRIES-1:0]             ent_present;
   logic [ENTRIES-1:0][HINT_W-1:0] ent_hint;
   logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
   logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
   logic [ENTRIES-1:0]             hits;
   logic [ENTRIES-1:0]             grant;
   logic                           any_hit;

   gh_tlb_store #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRIES(ENTRIES)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .fl_en(fl_en),
      .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_hint(fl_hint), .fl_present(fl_present),
      .ent_valid(ent_valid), .ent_present(ent_present), .ent_hint(ent_hint),
      .ent_vpn(ent_vpn), .ent_pfn(ent_pfn)
   );

   gh_tlb_match #(.VPN_W(VPN_W), .ENTRIES(ENTRIES)) u_match (
      .vpn(lk_vpn), .ent_valid(ent_valid), .ent_hint(ent_hint),
      .ent_vpn(ent_vpn), .hits(hits)
   );

   gh_tlb_prio #(.N(ENTRIES)) u_prio (
      .clk(clk), .rst_n(rst_n), .req(hits), .grant(grant), .any(any_hit)
   );

   logic             sel_present;
   logic [HINT_W-1:0] sel_hint;
   logic [PFN_W-1:0] sel_pfn;
   always_comb begin
      sel_present = 1'b0;
      sel_hint    = '0;
      sel_pfn     = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         sel_present = sel_present | (grant[i] & ent_present[i]);
         sel_hint    = sel_hint    | ({HINT_W{grant[i]}} & ent_hint[i]);
         sel_pfn     = sel_pfn     | ({PFN_W{grant[i]}} & ent_pfn[i]);
      end
   end

   logic [PFN_W-1:0] low_bits;
   logic             hit_d, fault_d;
   logic [PFN_W-1:0] pfn_d;
   assign low_bits = PFN_W'(lk_vpn[LOW_MAX-1:0] & low_mask(sel_hint));
   assign hit_d    = lk_req && any_hit && !flush;
   assign fault_d  = hit_d && !sel_present;
   assign pfn_d    = (hit_d && sel_present) ? (sel_pfn | low_bits) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_fault <= 1'b0;
         rs_pfn   <= '0;
      end else begin
         rs_valid <= lk_req;
         rs_hit   <= hit_d;
         rs_fault <= fault_d;
         rs_pfn   <= pfn_d;
      end
   end

   // R1
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rs_valid);
   // R5
   fault_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_fault |-> (rs_hit && rs_pfn == '0));
   // R6
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_hit |-> (!rs_fault && rs_pfn == '0));
   // R8
   flush_lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && lk_req) |=> !rs_hit);
endmodule

// File: tb/tb_gh_tlb.sv
module tb_gh_tlb;
   localparam int PERIOD = 10;
   localparam int VW = 16;
   localparam int PW = 12;
   localparam int NE = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_req = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic          rs_valid, rs_hit, rs_fault;
   logic [PW-1:0] rs_pfn;
   logic          fl_en = 1'b0;
   logic [VW-1:0] fl_vpn = '0;
   logic [PW-1:0] fl_pfn = '0;
   logic [1:0]    fl_hint = '0;
   logic          fl_present = 1'b0;
   logic          flush = 1'b0;

   int vectors = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   gh_tlb #(.VPN_W(VW), .PFN_W(PW), .ENTRIES(NE)) dut (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_fault(rs_fault), .rs_pfn(rs_pfn),
      .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_hint(fl_hint),
      .fl_present(fl_present), .flush(flush)
   );

   // reference model
   bit          m_valid [NE];
   bit          m_pres  [NE];
   logic [1:0]  m_hint  [NE];
   logic [VW-1:0] m_vpn [NE];
   logic [PW-1:0] m_pfn [NE];
   int          m_ptr;

   function automatic logic [VW-1:0] span(input logic [1:0] h);
      return VW'((1 << h) - 1);
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp, input string what);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic step(input bit req, input logic [VW-1:0] vpn,
                       input bit fe, input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                       input logic [1:0] fh, input bit fpres, input bit fl, input string tag_in);
      bit exp_hit, exp_fault;
      logic [PW-1:0] exp_pfn;
      int w;
      string tag;
      lk_req = req; lk_vpn = vpn; fl_en = fe; fl_vpn = fv; fl_pfn = fp;
      fl_hint = fh; fl_present = fpres; flush = fl;
      exp_hit = 1'b0; exp_fault = 1'b0; exp_pfn = '0; w = -1;
      for (int i = 0; i < NE; i++) begin
         if (w < 0 && m_valid[i] && (((vpn ^ m_vpn[i]) & ~span(m_hint[i])) == '0)) w = i;
      end
      if (req && !fl && w >= 0) begin
         exp_hit = 1'b1;
         if (!m_pres[w]) exp_fault = 1'b1;
         else exp_pfn = m_pfn[w] | PW'(vpn & span(m_hint[w]));
      end
      if (tag_in != "") tag = tag_in;
      else if (fl) tag = "R8";
      else if (exp_fault) tag = "R5";
      else if (!exp_hit) tag = "R6";
      else if (w >= 0 && m_hint[w] != 2'd0) tag = "R3";
      else tag = "R2";
      @(posedge clk);
      if (fl) begin
         for (int i = 0; i < NE; i++) m_valid[i] = 1'b0;
         m_ptr = 0;
      end else if (fe) begin
         m_valid[m_ptr] = 1'b1;
         m_pres[m_ptr]  = fpres;
         m_hint[m_ptr]  = fh;
         m_vpn[m_ptr]   = fv & ~span(fh);
         m_pfn[m_ptr]   = fp & ~PW'(span(fh));
         m_ptr = (m_ptr + 1) % NE;
      end
      @(negedge clk);
      check("R1", 32'(rs_valid), 32'(req), "rs_valid");
      if (req) begin
         check(tag, 32'(rs_hit), 32'(exp_hit), "rs_hit");
         check(tag, 32'(rs_fault), 32'(exp_fault), "rs_fault");
         check(tag, 32'(rs_pfn), 32'(exp_pfn), "rs_pfn");
      end
   endtask

   task automatic look(input logic [VW-1:0] v, input string tag);
      step(1, v, 0, '0, '0, 2'd0, 0, 0, tag);
   endtask

   task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [1:0] h, input bit pr);
      step(0, '0, 1, v, p, h, pr, 0, "R7");
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      for (int i = 0; i < NE; i++) begin
         m_valid[i] = 0; m_pres[i] = 0; m_hint[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
      end
      m_ptr = 0;
      void'($urandom(32'd20240607));
      repeat (4) @(negedge clk);
      // R11: reset state
      check("R11", 32'(rs_valid), 32'd0, "rs_valid in reset");
      check("R11", 32'(rs_hit), 32'd0, "rs_hit in reset");
      check("R11", 32'(rs_fault), 32'd0, "rs_fault in reset");
      rst_n = 1'b1;
      @(negedge clk);
      look(16'h0000, "R11");
      // R2 single page
      fill(16'h0123, 12'h0A5, 2'd0, 1);
      look(16'h0123, "R2");
      look(16'h0122, "R2");
      // R3 R4 eight-page block, unaligned fill values
      fill(16'h0207, 12'h3F5, 2'd3, 1);
      look(16'h0205, "R4");
      look(16'h0200, "R3");
      look(16'h0208, "R3");
      // R5 absent two-page block
      fill(16'h0300, 12'h111, 2'd1, 0);
      look(16'h0301, "R5");
      // R10 lookup during fill
      step(1, 16'h0402, 1, 16'h0400, 12'h884, 2'd2, 1, 0, "R10");
      look(16'h0402, "R10");
      // R9 overlapping entries, slot 1 wins over slot 4
      fill(16'h0206, 12'h777, 2'd0, 1);
      look(16'h0206, "R9");
      // R7 wrap: slots 5,6,7 then slot 0 replaced
      fill(16'h0500, 12'h500, 2'd0, 1);
      fill(16'h0600, 12'h600, 2'd0, 1);
      fill(16'h0700, 12'h700, 2'd0, 1);
      fill(16'h0900, 12'h900, 2'd0, 1);
      look(16'h0123, "R7");
      look(16'h0900, "R7");
      // R8 flush with lookup, then fill dropped during flush
      step(1, 16'h0205, 0, '0, '0, 2'd0, 0, 1, "R8");
      look(16'h0205, "R8");
      step(1, 16'h0206, 1, 16'h0A00, 12'h0A0, 2'd0, 1, 1, "R8");
      look(16'h0A00, "R8");
      // random phase
      for (int n = 0; n < 4000; n++) begin
         bit r, f, fl, pr;
         r  = ($urandom_range(0, 99) < 70);
         f  = ($urandom_range(0, 99) < 30);
         fl = ($urandom_range(0, 99) < 2);
         pr = ($urandom_range(0, 99) < 85);
         step(r, VW'($urandom_range(0, 63)), f, VW'($urandom_range(0, 63)),
              PW'($urandom), 2'($urandom_range(0, 3)), pr, fl, "");
      end
      step(0, '0, 0, '0, '0, 2'd0, 0, 0, "R1");
      finished = 1'b1;
      summary();
   end
endmodule